// File: doc/BRIEF.md
# Keyed Restart and Power-Off Controller

This block is a small register-mapped controller on a plain 32-bit register bus. Software uses it to ask the system for a restart or a power-off. It holds three 32-bit registers: a control register, a status register and a watchdog register. Every write has to carry a fixed key byte in its upper eight bits. A write without the key changes nothing and sets a sticky error flag. A write that carries the key is stored with the key byte cleared to zero.

Setting the trigger bit in an accepted control-register write produces exactly one single-cycle request, one clock after the write strobe. The request is a power-off request when the low twelve bits of the status register hold the halt code 0x555. Otherwise it is a reboot request. The watchdog register only stores data and starts no timer. Reads return registered data one cycle after the read strobe.

Top module: `rst_pwr_ctrl`

## Requirements
- R1: A write whose data bits 31:24 differ from 0x5A changes no register at any offset.
- R2: An accepted write (bits 31:24 equal 0x5A) stores the write data with bits 31:24 cleared to zero.
- R3: Control is at byte offset 0x1C, status at 0x20 and watchdog at 0x24. `rd_data` shows the addressed register in the cycle after `rd_en`. The watchdog register reads back what was written and has no other effect.
- R4: A read of any other byte offset in the 0x200-byte window, misaligned ones included, returns zero. An accepted write to such an offset changes no register.
- R5: After reset, control reads 0x00000102, status reads 0x00001000 and watchdog reads 0x00000000.
- R6: An accepted write to control with bit 5 set, while status bits 11:0 differ from 0x555, raises `reboot_req` for exactly one cycle, in the cycle after the write strobe.
- R7: The same trigger, while status bits 11:0 equal 0x555, raises `poweroff_req` for exactly one cycle, in the cycle after the write strobe. The check uses the status value held before the write.
- R8: `reboot_req` and `poweroff_req` are never high together. Neither rises without an accepted trigger write to control: a write without bit 5, a rejected write, and a write to another offset raise neither.
- R9: `key_err` is low after reset. It goes high in the cycle after a write with a wrong key and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 9 | Byte offset within the register window |
| wr_data | input | 32 | Write data; bits 31:24 carry the key |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en`, otherwise zero |
| reboot_req | output | 1 | Single-cycle restart request |
| poweroff_req | output | 1 | Single-cycle power-off request |
| key_err | output | 1 | Sticky flag for writes with a wrong key |

## Verification
The bench builds the block with its default 9-bit offset and the default register offsets and reset values. The window is then only 128 words, so every word offset is read and written, together with misaligned offsets. All 256 key byte values are tried against the watchdog register. Every one of the 4096 twelve-bit halt codes is stored in status and followed by a trigger, so the power-off versus reboot choice is checked for every code, with pulse width, the two-pulse exclusion and the stickiness of the key error flag checked along the way.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    localparam int DW       = 32;
    localparam int KEY_W    = 8;
    localparam logic [KEY_W-1:0] KEY_VAL = 8'h5A;
    localparam int TRIG_BIT = 5;
    localparam int HALT_W   = 12;
    localparam logic [HALT_W-1:0] HALT_CODE = 12'h555;
    localparam int N_REG    = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_WDOG = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_REBOOT   = 2'd1,
        ACT_POWEROFF = 2'd2
    } action_e;

    typedef struct packed {
        logic           wr_ok;
        logic           wr_bad;
        logic           rd;
        reg_sel_e       sel;
        logic [DW-1:0]  data;
    } bus_req_t;

    function automatic logic [DW-1:0] strip_key(input logic [DW-1:0] d);
        return {{KEY_W{1'b0}}, d[DW-KEY_W-1:0]};
    endfunction

    function automatic logic key_match(input logic [DW-1:0] d);
        return d[DW-1 -: KEY_W] == KEY_VAL;
    endfunction

    function automatic reg_sel_e sel_of_index(input int i);
        return reg_sel_e'(i + 1);
    endfunction
endpackage

// File: rtl/rpc_decode.sv
module rpc_decode
    import rpc_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 9'h01C,
    parameter logic [ADDR_W-1:0] STAT_OFS = 9'h020,
    parameter logic [ADDR_W-1:0] WDOG_OFS = 9'h024
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output bus_req_t          req
);
    logic     key_ok;
    reg_sel_e sel;

    always_comb begin
        key_ok = key_match(wr_data);
        if (addr == CTRL_OFS)      sel = SEL_CTRL;
        else if (addr == STAT_OFS) sel = SEL_STAT;
        else if (addr == WDOG_OFS) sel = SEL_WDOG;
        else                       sel = SEL_NONE;
    end

    always_comb begin
        req.wr_ok  = wr_en && key_ok;
        req.wr_bad = wr_en && !key_ok;
        req.rd     = rd_en;
        req.sel    = sel;
        req.data   = wr_data;
    end
endmodule

// File: rtl/rpc_regfile.sv
module rpc_regfile
    import rpc_pkg::*;
#(
    parameter logic [DW-1:0] CTRL_RST = 32'h0000_0102,
    parameter logic [DW-1:0] STAT_RST = 32'h0000_1000,
    parameter logic [DW-1:0] WDOG_RST = 32'h0000_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] wdog_q,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] regs [N_REG];
    logic [DW-1:0] rd_q;
    logic [DW-1:0] rd_mux;

    function automatic logic [DW-1:0] rst_of(input int i);
        case (i)
            0:       return CTRL_RST;
            1:       return STAT_RST;
            default: return WDOG_RST;
        endcase
    endfunction

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        localparam reg_sel_e MY_SEL = sel_of_index(i);
        localparam logic [DW-1:0] MY_RST = rst_of(i);
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= MY_RST;
            else if (req.wr_ok && req.sel == MY_SEL)
                regs[i] <= strip_key(req.data);
        end
    end

    always_comb begin
        case (req.sel)
            SEL_CTRL: rd_mux = regs[0];
            SEL_STAT: rd_mux = regs[1];
            SEL_WDOG: rd_mux = regs[2];
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (req.rd) rd_q <= rd_mux;
        else             rd_q <= '0;
    end

    assign ctrl_q  = regs[0];
    assign stat_q  = regs[1];
    assign wdog_q  = regs[2];
    assign rd_data = rd_q;
endmodule

// File: rtl/rpc_action.sv
module rpc_action
    import rpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [HALT_W-1:0] halt_code,
    output logic              reboot_req,
    output logic              poweroff_req,
    output logic              key_err
);
    action_e act_d, act_q;
    logic    trig;
    logic    err_q;

    always_comb begin
        trig  = req.wr_ok && req.sel == SEL_CTRL && req.data[TRIG_BIT];
        act_d = ACT_NONE;
        if (trig)
            act_d = (halt_code == HALT_CODE) ? ACT_POWEROFF : ACT_REBOOT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= ACT_NONE;
            err_q <= 1'b0;
        end else begin
            act_q <= act_d;
            if (req.wr_bad) err_q <= 1'b1;
        end
    end

    assign reboot_req   = act_q == ACT_REBOOT;
    assign poweroff_req = act_q == ACT_POWEROFF;
    assign key_err      = err_q;
endmodule

// File: rtl/rst_pwr_ctrl.sv
module rst_pwr_ctrl
    import rpc_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 9'h01C,
    parameter logic [ADDR_W-1:0] STAT_OFS = 9'h020,
    parameter logic [ADDR_W-1:0] WDOG_OFS = 9'h024,
    parameter logic [31:0] CTRL_RST = 32'h0000_0102,
    parameter logic [31:0] STAT_RST = 32'h0000_1000,
    parameter logic [31:0] WDOG_RST = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              reboot_req,
    output logic              poweroff_req,
    output logic              key_err
);
    bus_req_t      req;
    logic [DW-1:0] ctrl_q, stat_q, wdog_q;

    rpc_decode #(
        .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS),
        .STAT_OFS(STAT_OFS), .WDOG_OFS(WDOG_OFS)
    ) u_decode (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .req(req)
    );

    rpc_regfile #(
        .CTRL_RST(CTRL_RST), .STAT_RST(STAT_RST), .WDOG_RST(WDOG_RST)
    ) u_regs (
        .clk(clk), .rst(rst), .req(req),
        .ctrl_q(ctrl_q), .stat_q(stat_q), .wdog_q(wdog_q),
        .rd_data(rd_data)
    );

    rpc_action u_action (
        .clk(clk), .rst(rst), .req(req),
        .halt_code(stat_q[HALT_W-1:0]),
        .reboot_req(reboot_req), .poweroff_req(poweroff_req),
        .key_err(key_err)
    );
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker
    import rpc_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 9'h01C
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wr_data,
    input logic              reboot_req,
    input logic              poweroff_req,
    input logic              key_err,
    input logic [DW-1:0]     ctrl_q,
    input logic [DW-1:0]     stat_q,
    input logic [DW-1:0]     wdog_q
);
    logic bad_wr, trig_wr;
    assign bad_wr  = wr_en && wr_data[31:24] != 8'h5A;
    assign trig_wr = wr_en && wr_data[31:24] == 8'h5A && addr == CTRL_OFS && wr_data[5];

    p_bad_key_hold_r1: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> ($stable(ctrl_q) && $stable(stat_q) && $stable(wdog_q)));

    p_key_byte_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[31:24] == 8'h00 && stat_q[31:24] == 8'h00 && wdog_q[31:24] == 8'h00));

    p_trigger_fires_r6: assert property (@(posedge clk) disable iff (rst)
        trig_wr |=> (reboot_req || poweroff_req));

    p_reboot_cause_r6: assert property (@(posedge clk) disable iff (rst)
        reboot_req |-> ($past(trig_wr) && $past(stat_q[11:0]) != 12'h555));

    p_poweroff_cause_r7: assert property (@(posedge clk) disable iff (rst)
        poweroff_req |-> ($past(trig_wr) && $past(stat_q[11:0]) == 12'h555));

    p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(reboot_req && poweroff_req));

    p_err_set_r9: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> key_err);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        key_err |=> key_err);
endmodule

bind rst_pwr_ctrl rpc_checker #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .reboot_req(reboot_req), .poweroff_req(poweroff_req), .key_err(key_err),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .wdog_q(wdog_q)
);

// File: tb/test_rst_pwr_ctrl.sv
`timescale 1ns/1ps
module test_rst_pwr_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        reboot_req, poweroff_req, key_err;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_ctrl, m_stat, m_wdog;
    logic        p_reb, p_pof;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    rst_pwr_ctrl i_rst_pwr_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .reboot_req(reboot_req),
        .poweroff_req(poweroff_req), .key_err(key_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_at(input logic [8:0] a);
        case (a)
            9'h01C:  return m_ctrl;
            9'h020:  return m_stat;
            9'h024:  return m_wdog;
            default: return 32'h0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_ctrl = 32'h0000_0102;
        m_stat = 32'h0000_1000;
        m_wdog = 32'h0000_0000;
    endtask

    // Strobe at one negedge, sample the registered pulses at the next one.
    task automatic do_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr = a;
        wr_data = d;
        @(negedge clk);
        p_reb = reboot_req;
        p_pof = poweroff_req;
        wr_en = 1'b0;
        if (d[31:24] == 8'h5A) begin
            case (a)
                9'h01C: m_ctrl = {8'h00, d[23:0]};
                9'h020: m_stat = {8'h00, d[23:0]};
                9'h024: m_wdog = {8'h00, d[23:0]};
                default: ;
            endcase
        end
    endtask

    task automatic do_read(input logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        addr = a;
        @(negedge clk);
        v = rd_data;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // R5 / R9: reset state
        @(negedge clk);
        chk("R9 key_err after reset", {31'b0, key_err}, 32'h0);
        chk("R8 no pulse after reset", {30'b0, reboot_req, poweroff_req}, 32'h0);
        do_read(9'h01C, rv); chk("R5 ctrl reset", rv, 32'h0000_0102);
        do_read(9'h020, rv); chk("R5 stat reset", rv, 32'h0000_1000);
        do_read(9'h024, rv); chk("R5 wdog reset", rv, 32'h0000_0000);

        // R3 / R4: sweep every word offset of the window
        for (int w = 0; w < 128; w++) begin
            do_read(9'(w * 4), rv);
            chk("R4 R3 read sweep", rv, expect_at(9'(w * 4)));
        end

        // R1 / R2 / R3: all key byte values against the watchdog register
        for (int k = 0; k < 256; k++) begin
            logic [31:0] d;
            d = {8'(k), 8'(k ^ 8'h3C), 8'hC3, 8'(255 - k)};
            do_write(9'h024, d);
            chk("R8 wdog write no pulse", {30'b0, p_reb, p_pof}, 32'h0);
            do_read(9'h024, rv);
            chk("R1 R2 R3 wdog key sweep", rv, m_wdog);
        end
        chk("R9 key_err after bad key", {31'b0, key_err}, 32'h1);
        do_read(9'h01C, rv); chk("R1 ctrl untouched", rv, m_ctrl);
        do_read(9'h020, rv); chk("R1 stat untouched", rv, m_stat);

        // R4: keyed writes to every unmapped offset, trigger bit set
        for (int w = 0; w < 128; w++) begin
            logic [8:0] a;
            a = 9'(w * 4);
            if (a != 9'h01C && a != 9'h020 && a != 9'h024) begin
                do_write(a, 32'h5AFF_FFFF);
                chk("R8 unmapped write no pulse", {30'b0, p_reb, p_pof}, 32'h0);
            end
        end
        do_write(9'h01D, 32'h5AFF_FFFF);
        chk("R8 misaligned write no pulse", {30'b0, p_reb, p_pof}, 32'h0);
        do_write(9'h021, 32'h5AFF_FFFF);
        do_read(9'h01D, rv); chk("R4 misaligned read", rv, 32'h0);
        do_read(9'h01C, rv); chk("R4 ctrl unchanged", rv, m_ctrl);
        do_read(9'h020, rv); chk("R4 stat unchanged", rv, m_stat);
        do_read(9'h024, rv); chk("R4 wdog unchanged", rv, m_wdog);

        // R8: control write without trigger bit
        do_write(9'h01C, 32'h5A12_3411);
        chk("R8 ctrl no trigger", {30'b0, p_reb, p_pof}, 32'h0);
        do_read(9'h01C, rv); chk("R2 ctrl stored", rv, 32'h0012_3411);

        // R6 / R7: every halt code, followed by a trigger
        for (int h = 0; h < 4096; h++) begin
            logic [31:0] sd;
            logic        want_pof;
            sd = {8'h5A, 12'(h * 5 + 1), 12'(h)};
            do_write(9'h020, sd);
            want_pof = (h == 12'h555);
            do_write(9'h01C, 32'h5A00_0020 | 32'(h << 8));
            chk(want_pof ? "R7 poweroff pulse" : "R6 reboot pulse",
                {30'b0, p_reb, p_pof}, want_pof ? 32'h1 : 32'h2);
            @(negedge clk);
            chk("R6 R7 pulse width one cycle", {30'b0, reboot_req, poweroff_req}, 32'h0);
        end
        do_read(9'h020, rv); chk("R3 stat readback", rv, m_stat);
        do_read(9'h01C, rv); chk("R2 ctrl readback", rv, m_ctrl);

        // R8: rejected trigger while the halt code is set
        do_write(9'h020, 32'h5AAB_C555);
        do_write(9'h01C, 32'hA500_0020);
        chk("R8 bad key trigger", {30'b0, p_reb, p_pof}, 32'h0);
        do_write(9'h01C, 32'h5A00_0020);
        chk("R7 poweroff with upper status bits", {30'b0, p_reb, p_pof}, 32'h1);

        // R9: reset clears the flag; R5 reset values return
        chk("R9 key_err still set", {31'b0, key_err}, 32'h1);
        do_reset();
        @(negedge clk);
        chk("R9 key_err cleared by reset", {31'b0, key_err}, 32'h0);
        do_read(9'h01C, rv); chk("R5 ctrl after reset", rv, 32'h0000_0102);
        do_read(9'h020, rv); chk("R5 stat after reset", rv, 32'h0000_1000);
        do_read(9'h024, rv); chk("R5 wdog after reset", rv, 32'h0000_0000);
        do_write(9'h01C, 32'h5A00_0020);
        chk("R6 reboot from reset status", {30'b0, p_reb, p_pof}, 32'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule